// File: doc/BRIEF.md
# Power-Save Clock Divider with Activity Switchback

This block turns a free-running high-frequency clock into a clock-enable pulse for the rest of the system. Software chooses a ratio of 1, 2, 4 or 8 through a two-bit divide field. A power-save bit overrides that field and slows the enable to one pulse every 2^PM_SHIFT input cycles, which is 256 by default. A stop bit freezes the enable entirely until a wake input arrives. Stopping leaves the ratio settings as they were, so the same speed returns on wake.

When the switchback enable is set, activity events end power-save mode in hardware and return the system to full speed. The events are enabled external interrupts, falling edges on receive pins of enabled serial ports, transmit-buffer writes, SPI buffer writes as master, slave select asserted in SPI slave mode, an I2C start, a supply-monitor interrupt, RTC time-of-day and subsecond alarms, an ADC conversion start and debug entry. While such an event is active and switchback is enabled, a write cannot enter power-save mode. This stops software from slowing down in the middle of the activity that needs full speed.

Top module: `clkdiv_swb`

## Requirements
- R1: With power-save off, divide field 00, 01, 10 and 11 give one `clk_en` pulse every 1, 2, 4 and 8 input cycles.
- R2: With power-save on, `clk_en` pulses once every 2^PM_SHIFT cycles (256 by default), whatever the divide field holds.
- R3: A ratio change written mid-interval takes effect only at the next pulse, so the current interval is never shortened.
- R4: Clearing power-save by a software write sets the divide field to 00 (divide by 1), whatever divide value that write carries.
- R5: When power-save and switchback enable are both 1 and any switchback source is active, power-save clears at the next edge and the divide field becomes 00.
- R6: A write that sets power-save with switchback enable 1 in the written value has no effect on power-save while any switchback source is active.
- R7: A serial receive falling edge counts as a source only after a two-flop synchroniser. Power-save clears at the third rising edge after the pin falls, and only if that lane's receive enable is 1.
- R8: Each listed source clears power-save on its own. An external interrupt counts only when its enable bit is 1. An SPI buffer write counts only with `spi_master` set. Slave select counts only with `spi_slave` set.
- R9: While stopped, `clk_en` stays low, configuration writes and switchback are ignored, and all settings hold. `stop_wake` resumes at the ratio held before stop.
- R10: After reset: divide field 00, power-save off, switchback off, not stopped, and `clk_en` high every cycle.
- R11: With switchback enable 0, sources leave power-save mode set.
- R12: If a switchback fires in the same cycle as a write that sets power-save, the switchback wins and power-save ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_div | input | 2 | Divide field written (00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8) |
| cfg_pm | input | 1 | Power-save bit written |
| cfg_swb | input | 1 | Switchback enable written |
| cfg_stop | input | 1 | Stop request written |
| stop_wake | input | 1 | Leave stop state |
| ext_irq_flag | input | NUM_EXT | External interrupt flags |
| ext_irq_en | input | NUM_EXT | External interrupt enables |
| rx_pin | input | NUM_UART | Asynchronous serial receive pins |
| rx_en | input | NUM_UART | Serial receive enables |
| tx_buf_wr | input | NUM_UART | Serial transmit buffer write strobes |
| spi_buf_wr | input | 1 | SPI buffer write strobe |
| spi_master | input | 1 | SPI in master mode |
| spi_slave | input | 1 | SPI in slave mode |
| spi_ssel_n | input | 1 | SPI slave select, active low |
| i2c_start_irq | input | 1 | I2C start interrupt |
| svm_irq | input | 1 | Supply-monitor interrupt |
| rtc_tod_alarm | input | 1 | RTC time-of-day alarm |
| rtc_sub_alarm | input | 1 | RTC subsecond alarm |
| adc_start | input | 1 | ADC conversion start |
| dbg_enter | input | 1 | Debug-mode entry |
| clk_en | output | 1 | Divided clock-enable pulse |
| pm_active | output | 1 | Power-save mode state |
| div_sel | output | 2 | Current divide field |
| swb_active | output | 1 | Switchback enable state |
| stop_active | output | 1 | Stop state |

## Verification
The bench builds the block with NUM_EXT = 3, NUM_UART = 2 and PM_SHIFT = 8. This keeps the true 256-cycle power-save interval short enough to measure end to end. Two serial lanes allow a check that one lane's receive enable does not gate the other. Three external-interrupt lanes allow a disabled lane to be tested beside an enabled one. Each source is fired alone against an armed power-save state, and interval lengths are counted pulse to pulse across ratio changes, stop and wake.

// File: rtl/clkdiv_pkg.sv
// Shared encodings for the power-save clock divider.
// Assumes: the divide field is two bits wide and its code is a power-of-two exponent.
package clkdiv_pkg;
    typedef enum logic [1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_BY8 = 2'b11
    } div_sel_e;
endpackage

// File: rtl/clkdiv_rx_edge.sv
// Detects falling edges on asynchronous serial receive pins.
// Each lane passes through two synchroniser flops and one history flop.
// An edge is reported only when that lane's receive enable is set.
// Assumes: pins idle high, so the flops reset to 1.
module clkdiv_rx_edge #(
    parameter int NUM_UART = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_UART-1:0] rx_pin,
    input  logic [NUM_UART-1:0] rx_en,
    output logic [NUM_UART-1:0] rx_fall
);
    for (genvar g = 0; g < NUM_UART; g++) begin : g_lane
        logic s1_q, s2_q, s3_q;

        // Synchronise the pin and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
                s3_q <= 1'b1;
            end else begin
                s1_q <= rx_pin[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        // Report a high-to-low change on the synchronised pin.
        assign rx_fall[g] = rx_en[g] & s3_q & ~s2_q;
    end
endmodule

// File: rtl/clkdiv_wake_agg.sv
// Merges every switchback source into one level.
// Each source is qualified by the enable or mode that the requirements name.
// Assumes: all inputs other than the receive edges are synchronous to clk.
module clkdiv_wake_agg #(
    parameter int NUM_EXT  = 4,
    parameter int NUM_UART = 2
) (
    input  logic [NUM_EXT-1:0]  ext_irq_flag,
    input  logic [NUM_EXT-1:0]  ext_irq_en,
    input  logic [NUM_UART-1:0] rx_fall,
    input  logic [NUM_UART-1:0] tx_buf_wr,
    input  logic                spi_buf_wr,
    input  logic                spi_master,
    input  logic                spi_slave,
    input  logic                spi_ssel_n,
    input  logic                i2c_start_irq,
    input  logic                svm_irq,
    input  logic                rtc_tod_alarm,
    input  logic                rtc_sub_alarm,
    input  logic                adc_start,
    input  logic                dbg_enter,
    output logic                src_any
);
    // OR together all qualified activity sources.
    always_comb begin
        src_any = (|(ext_irq_flag & ext_irq_en))
                | (|rx_fall)
                | (|tx_buf_wr)
                | (spi_buf_wr & spi_master)
                | (spi_slave & ~spi_ssel_n)
                | i2c_start_irq
                | svm_irq
                | rtc_tod_alarm
                | rtc_sub_alarm
                | adc_start
                | dbg_enter;
    end
endmodule

// File: rtl/clkdiv_mode_ctrl.sv
// Holds the divide field and the power-save, switchback and stop bits.
// Applies software writes, the write blocking rule and automatic switchback.
// Assumes: cfg_wr is a one-cycle strobe, and writes are ignored while stopped.
module clkdiv_mode_ctrl
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_div,
    input  logic       cfg_pm,
    input  logic       cfg_swb,
    input  logic       cfg_stop,
    input  logic       stop_wake,
    input  logic       src_any,
    output logic [1:0] div_sel,
    output logic       pm_q,
    output logic       swb_q,
    output logic       stop_q
);
    div_sel_e div_q;
    logic     sb_fire;
    logic     pm_blocked;

    // Switchback fires on activity while both mode bits are set.
    assign sb_fire    = pm_q & swb_q & src_any;
    // A power-save entry attempt is refused during active sources.
    assign pm_blocked = cfg_pm & ~pm_q & cfg_swb & src_any;

    // Update the mode registers from writes, switchback and wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_BY1;
            pm_q   <= 1'b0;
            swb_q  <= 1'b0;
            stop_q <= 1'b0;
        end else if (stop_q) begin
            if (stop_wake) stop_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                swb_q  <= cfg_swb;
                stop_q <= cfg_stop;
            end
            if (sb_fire) begin
                pm_q  <= 1'b0;
                div_q <= DIV_BY1;
            end else if (cfg_wr) begin
                if (pm_blocked) begin
                    div_q <= div_sel_e'(cfg_div);
                end else if (cfg_pm) begin
                    pm_q  <= 1'b1;
                    div_q <= div_sel_e'(cfg_div);
                end else begin
                    pm_q  <= 1'b0;
                    div_q <= pm_q ? DIV_BY1 : div_sel_e'(cfg_div);
                end
            end
        end
    end

    assign div_sel = div_q;

    // R4
    // Any exit from power-save leaves the divide field at divide-by-1.
    pm_exit_div1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pm_q) |-> (div_q == DIV_BY1));

    // R5
    // Armed switchback with an active source clears power-save.
    sb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_q && swb_q && src_any && !stop_q) |=> (!pm_q && div_q == DIV_BY1));

    // R6
    // An entry write during activity with switchback enabled is refused.
    pm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_pm && cfg_swb && src_any && !pm_q && !stop_q) |=> !pm_q);

    // R9
    // Settings hold while stopped.
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> ($stable(div_q) && $stable(pm_q) && $stable(swb_q)));
endmodule

// File: rtl/clkdiv_ratio_cnt.sv
// Down-counter that emits one clk_en pulse per ratio interval.
// The ratio is sampled only when the count reloads at a pulse, so a change never shortens an interval.
// Assumes: PM_SHIFT >= 3, so the counter can hold the divide-by-8 reload.
module clkdiv_ratio_cnt #(
    parameter int PM_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       pm,
    input  logic       stop,
    output logic       clk_en
);
    localparam int CNT_W = PM_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Pick the interval length minus one for the current mode.
    always_comb begin
        if (pm) begin
            reload = '1;
        end else begin
            case (div_sel)
                2'b00:   reload = CNT_W'(0);
                2'b01:   reload = CNT_W'(1);
                2'b10:   reload = CNT_W'(3);
                default: reload = CNT_W'(7);
            endcase
        end
    end

    // Count down, reloading at terminal count and holding in stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!stop) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign clk_en = !stop && (cnt_q == '0);

    // R3
    // Between pulses the count only steps down by one.
    no_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9
    // No enable pulse while stopped.
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> !clk_en);
endmodule

// File: rtl/clkdiv_swb.sv
// Top of the power-save clock divider with activity switchback.
// It ties together receive-edge detection, source merging, mode control and the ratio counter.
// Assumes: one clock domain except rx_pin, which is synchronised inside.
module clkdiv_swb #(
    parameter int NUM_EXT  = 4,
    parameter int NUM_UART = 2,
    parameter int PM_SHIFT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_div,
    input  logic                cfg_pm,
    input  logic                cfg_swb,
    input  logic                cfg_stop,
    input  logic                stop_wake,
    input  logic [NUM_EXT-1:0]  ext_irq_flag,
    input  logic [NUM_EXT-1:0]  ext_irq_en,
    input  logic [NUM_UART-1:0] rx_pin,
    input  logic [NUM_UART-1:0] rx_en,
    input  logic [NUM_UART-1:0] tx_buf_wr,
    input  logic                spi_buf_wr,
    input  logic                spi_master,
    input  logic                spi_slave,
    input  logic                spi_ssel_n,
    input  logic                i2c_start_irq,
    input  logic                svm_irq,
    input  logic                rtc_tod_alarm,
    input  logic                rtc_sub_alarm,
    input  logic                adc_start,
    input  logic                dbg_enter,
    output logic                clk_en,
    output logic                pm_active,
    output logic [1:0]          div_sel,
    output logic                swb_active,
    output logic                stop_active
);
    logic [NUM_UART-1:0] rx_fall;
    logic                src_any;

    clkdiv_rx_edge #(.NUM_UART(NUM_UART)) u_rx_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_pin  (rx_pin),
        .rx_en   (rx_en),
        .rx_fall (rx_fall)
    );

    clkdiv_wake_agg #(.NUM_EXT(NUM_EXT), .NUM_UART(NUM_UART)) u_wake_agg (
        .ext_irq_flag  (ext_irq_flag),
        .ext_irq_en    (ext_irq_en),
        .rx_fall       (rx_fall),
        .tx_buf_wr     (tx_buf_wr),
        .spi_buf_wr    (spi_buf_wr),
        .spi_master    (spi_master),
        .spi_slave     (spi_slave),
        .spi_ssel_n    (spi_ssel_n),
        .i2c_start_irq (i2c_start_irq),
        .svm_irq       (svm_irq),
        .rtc_tod_alarm (rtc_tod_alarm),
        .rtc_sub_alarm (rtc_sub_alarm),
        .adc_start     (adc_start),
        .dbg_enter     (dbg_enter),
        .src_any       (src_any)
    );

    clkdiv_mode_ctrl u_mode_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_div   (cfg_div),
        .cfg_pm    (cfg_pm),
        .cfg_swb   (cfg_swb),
        .cfg_stop  (cfg_stop),
        .stop_wake (stop_wake),
        .src_any   (src_any),
        .div_sel   (div_sel),
        .pm_q      (pm_active),
        .swb_q     (swb_active),
        .stop_q    (stop_active)
    );

    clkdiv_ratio_cnt #(.PM_SHIFT(PM_SHIFT)) u_ratio_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .pm      (pm_active),
        .stop    (stop_active),
        .clk_en  (clk_en)
    );

    // R11
    // Without switchback enabled, power-save ends only through a write.
    no_swb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_active && !swb_active && !cfg_wr) |=> pm_active);
endmodule

// File: tb/clkdiv_swb_tb.sv
`timescale 1ns/1ps
// Directed bench for clkdiv_swb: one task per scenario, each checking its own results.
module clkdiv_swb_tb_top;
    localparam int NE = 3;
    localparam int NU = 2;
    localparam int PS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_div = 2'b00;
    logic          cfg_pm = 1'b0, cfg_swb = 1'b0, cfg_stop = 1'b0, stop_wake = 1'b0;
    logic [NE-1:0] ext_irq_flag = '0, ext_irq_en = '0;
    logic [NU-1:0] rx_pin = '1, rx_en = '0, tx_buf_wr = '0;
    logic          spi_buf_wr = 1'b0, spi_master = 1'b0, spi_slave = 1'b0, spi_ssel_n = 1'b1;
    logic          i2c_start_irq = 1'b0, svm_irq = 1'b0, rtc_tod_alarm = 1'b0, rtc_sub_alarm = 1'b0;
    logic          adc_start = 1'b0, dbg_enter = 1'b0;
    logic          clk_en, pm_active, swb_active, stop_active;
    logic [1:0]    div_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_swb #(.NUM_EXT(NE), .NUM_UART(NU), .PM_SHIFT(PS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_pm(cfg_pm),
        .cfg_swb(cfg_swb), .cfg_stop(cfg_stop), .stop_wake(stop_wake),
        .ext_irq_flag(ext_irq_flag), .ext_irq_en(ext_irq_en), .rx_pin(rx_pin), .rx_en(rx_en),
        .tx_buf_wr(tx_buf_wr), .spi_buf_wr(spi_buf_wr), .spi_master(spi_master),
        .spi_slave(spi_slave), .spi_ssel_n(spi_ssel_n), .i2c_start_irq(i2c_start_irq),
        .svm_irq(svm_irq), .rtc_tod_alarm(rtc_tod_alarm), .rtc_sub_alarm(rtc_sub_alarm),
        .adc_start(adc_start), .dbg_enter(dbg_enter), .clk_en(clk_en), .pm_active(pm_active),
        .div_sel(div_sel), .swb_active(swb_active), .stop_active(stop_active)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One control write, visible on the outputs at the following falling edge.
    task automatic wr(input logic [1:0] d, input logic pm, input logic swb, input logic stp);
        cfg_wr = 1'b1; cfg_div = d; cfg_pm = pm; cfg_swb = swb; cfg_stop = stp;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_pulse();
        while (!clk_en) @(negedge clk);
    endtask

    // Falling edges from a pulse to the next pulse.
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en);
    endtask

    task automatic t_reset();
        int n;
        check("R10", "div_sel", div_sel, 0);
        check("R10", "pm_active", pm_active, 0);
        check("R10", "swb_active", swb_active, 0);
        check("R10", "stop_active", stop_active, 0);
        check("R10", "clk_en", clk_en, 1);
        gap(n);
        check("R10", "reset interval", n, 1);
    endtask

    task automatic t_divs();
        int n;
        for (int d = 0; d < 4; d++) begin
            wr(2'(d), 1'b0, 1'b0, 1'b0);
            wait_pulse();
            gap(n);
            gap(n);
            check("R1", $sformatf("interval code %0d", d), n, 1 << d);
        end
    endtask

    task automatic t_pm();
        int n;
        wr(2'b11, 1'b1, 1'b0, 1'b0);
        check("R2", "pm_active set", pm_active, 1);
        wait_pulse();
        gap(n);
        gap(n);
        check("R2", "power-save interval", n, 256);
        wr(2'b10, 1'b0, 1'b0, 1'b0);
        check("R4", "div after clear", div_sel, 0);
        check("R4", "pm after clear", pm_active, 0);
        wait_pulse();
        gap(n);
        gap(n);
        check("R4", "interval after clear", n, 1);
    endtask

    task automatic t_ratio_change();
        int n;
        wr(2'b11, 1'b0, 1'b0, 1'b0);
        wait_pulse();
        gap(n);
        cfg_wr = 1'b1; cfg_div = 2'b00; cfg_pm = 1'b0; cfg_swb = 1'b0; cfg_stop = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        n = 1;
        while (!clk_en) begin
            @(negedge clk);
            n++;
        end
        check("R3", "interval holding change", n, 8);
        gap(n);
        check("R3", "interval after change", n, 1);
    endtask

    // Arm power-save with switchback, fire one source for a cycle, observe.
    task automatic t_src(input int which, input bit expect_clear, input string tag);
        wr(2'b01, 1'b1, 1'b1, 1'b0);
        case (which)
            0: begin ext_irq_en = 3'b010; ext_irq_flag = 3'b010; end
            1: begin ext_irq_en = 3'b010; ext_irq_flag = 3'b001; end
            2: tx_buf_wr = 2'b10;
            3: begin spi_master = 1'b1; spi_buf_wr = 1'b1; end
            4: begin spi_master = 1'b0; spi_buf_wr = 1'b1; end
            5: begin spi_slave = 1'b1; spi_ssel_n = 1'b0; end
            6: begin spi_slave = 1'b0; spi_ssel_n = 1'b0; end
            7: i2c_start_irq = 1'b1;
            8: svm_irq = 1'b1;
            9: rtc_tod_alarm = 1'b1;
            10: rtc_sub_alarm = 1'b1;
            11: adc_start = 1'b1;
            default: dbg_enter = 1'b1;
        endcase
        @(negedge clk);
        ext_irq_flag = '0; ext_irq_en = '0; tx_buf_wr = '0; spi_buf_wr = 1'b0;
        spi_master = 1'b0; spi_slave = 1'b0; spi_ssel_n = 1'b1; i2c_start_irq = 1'b0;
        svm_irq = 1'b0; rtc_tod_alarm = 1'b0; rtc_sub_alarm = 1'b0; adc_start = 1'b0;
        dbg_enter = 1'b0;
        check("R8", {tag, " pm"}, pm_active, expect_clear ? 0 : 1);
        if (expect_clear) check("R5", {tag, " div"}, div_sel, 0);
        wr(2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rx();
        wr(2'b01, 1'b1, 1'b1, 1'b0);
        rx_en = 2'b01;
        rx_pin = 2'b10;
        @(negedge clk);
        check("R7", "pm after 1 edge", pm_active, 1);
        @(negedge clk);
        check("R7", "pm after 2 edges", pm_active, 1);
        @(negedge clk);
        check("R7", "pm after 3 edges", pm_active, 0);
        rx_pin = 2'b11;
        repeat (4) @(negedge clk);
        wr(2'b01, 1'b1, 1'b1, 1'b0);
        rx_pin = 2'b01;
        repeat (5) @(negedge clk);
        check("R7", "disabled lane edge", pm_active, 1);
        rx_pin = 2'b11;
        repeat (4) @(negedge clk);
        rx_en = 2'b00;
        wr(2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_no_swb();
        wr(2'b00, 1'b1, 1'b0, 1'b0);
        dbg_enter = 1'b1;
        repeat (3) @(negedge clk);
        dbg_enter = 1'b0;
        check("R11", "pm with switchback off", pm_active, 1);
        wr(2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_block();
        svm_irq = 1'b1;
        @(negedge clk);
        wr(2'b10, 1'b1, 1'b1, 1'b0);
        check("R6", "blocked entry pm", pm_active, 0);
        check("R6", "blocked entry swb", swb_active, 1);
        wr(2'b10, 1'b1, 1'b0, 1'b0);
        check("R6", "entry with switchback off", pm_active, 1);
        svm_irq = 1'b0;
        @(negedge clk);
        wr(2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        wr(2'b01, 1'b1, 1'b1, 1'b0);
        i2c_start_irq = 1'b1;
        cfg_wr = 1'b1; cfg_div = 2'b11; cfg_pm = 1'b1; cfg_swb = 1'b0; cfg_stop = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
        i2c_start_irq = 1'b0;
        check("R12", "pm after collision", pm_active, 0);
        check("R12", "div after collision", div_sel, 0);
        check("R12", "swb after collision", swb_active, 0);
    endtask

    task automatic t_stop();
        int n;
        int pulses = 0;
        wr(2'b10, 1'b0, 1'b1, 1'b1);
        check("R9", "stop_active", stop_active, 1);
        wr(2'b00, 1'b1, 1'b0, 1'b0);
        adc_start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en) pulses++;
        end
        adc_start = 1'b0;
        check("R9", "pulses in stop", pulses, 0);
        check("R9", "div held", div_sel, 2);
        check("R9", "pm held", pm_active, 0);
        check("R9", "swb held", swb_active, 1);
        stop_wake = 1'b1;
        @(negedge clk);
        stop_wake = 1'b0;
        check("R9", "stop cleared", stop_active, 0);
        wait_pulse();
        gap(n);
        check("R9", "interval after wake", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divs();
        t_pm();
        t_ratio_change();
        t_src(0, 1'b1, "ext enabled");
        t_src(1, 1'b0, "ext disabled lane");
        t_src(2, 1'b1, "tx write");
        t_src(3, 1'b1, "spi master write");
        t_src(4, 1'b0, "spi write not master");
        t_src(5, 1'b1, "slave select");
        t_src(6, 1'b0, "select not slave");
        t_src(7, 1'b1, "i2c start");
        t_src(8, 1'b1, "supply monitor");
        t_src(9, 1'b1, "tod alarm");
        t_src(10, 1'b1, "subsecond alarm");
        t_src(11, 1'b1, "adc start");
        t_src(12, 1'b1, "debug entry");
        t_rx();
        t_no_swb();
        t_block();
        t_priority();
        t_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule